// File: doc/BRIEF.md
# Page Write Buffer with Deferred Commit

This block sits behind the serial-bus front end of a small byte-wide nonvolatile array of 256 locations. During a write transaction it collects the incoming data bytes in an eight-slot page buffer. The first data byte goes to the slot selected by the loaded start address. Each later byte moves to the next slot, and the pointer wraps inside the current page. Nothing reaches the array while the transaction is open.

When the bus Stop arrives, the block commits the buffered page. It walks the slots in ascending order and emits one registered array write strobe for each slot that received data. It then holds a busy flag for a self-timed write period whose length is a cycle-count parameter. While busy, the front end refuses every request, and the block ignores all of its inputs.

A write-protect input and a supply-good input veto the commit. A repeated Start before Stop abandons the buffered data, which is the address-setup step of a random read.

Top module: `pw_page_commit`

## Requirements
- R1: After reset, busy_o and mem_we_o are low.
- R2: The loaded address splits into a page base (bits 7:3) and a slot offset (bits 2:0). Each data byte goes to {base, offset}, and the offset then increments modulo 8, so a write past the page end wraps to the page start.
- R3: When more than 8 bytes arrive in one transaction, a later byte replaces the earlier byte of the same slot. Each array address is written at most once per commit, with the last byte received for it.
- R4: Only slots that received a byte in the current transaction produce an array write.
- R5: No array write happens before Stop, and mem_we_o is high only while busy_o is high.
- R6: A Stop that commits raises busy_o on the next cycle. busy_o then stays high for exactly 8 + WC_CYCLES cycles, and the writes come out in ascending slot order.
- R7: With wp_i high at Stop, the buffer is discarded, no write happens and busy_o stays low.
- R8: With supply_ok_i low at Stop, nothing commits and busy_o stays low. If supply_ok_i is low during the commit walk, no write strobe is issued for that cycle's slot.
- R9: A start_i pulse before Stop discards the buffered bytes, and the following Stop starts no write cycle.
- R10: While busy_o is high, addr_load_i, byte_vld_i, start_i and stop_i have no effect.
- R11: A Stop with no buffered byte starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_load_i | input | 1 | Load start address, begins a write transaction |
| addr_i | input | 8 | Start word address |
| byte_vld_i | input | 1 | One received data byte |
| byte_i | input | 8 | Data byte |
| start_i | input | 1 | Repeated Start seen on the bus |
| stop_i | input | 1 | Stop seen on the bus |
| wp_i | input | 1 | Write protect, high protects the whole array |
| supply_ok_i | input | 1 | Supply good, low inhibits writing |
| busy_o | output | 1 | Self-timed write cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 8 | Array write address |
| mem_data_o | output | 8 | Array write data |

## Verification
The assertions check, on every cycle, that a write strobe only appears inside a busy period and only one cycle after supply_ok_i was high. They also check that every busy period lasts exactly 8 + WC_CYCLES cycles, and that a protected Stop never raises busy. The bench scenarios cover the rest: which addresses receive which bytes under wrap and overwrite, that untouched slots stay unwritten, and that a repeated Start, an empty Stop, or pulses during busy leave no trace. The bench shows these effects through the write strobes and the busy flag.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WAIT = 2'd2
  } pw_state_e;
endpackage

// File: rtl/pw_buffer.sv
module pw_buffer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     wr_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     clear_i,
  input  logic [PAGE_W-1:0]        rd_idx_i,
  output logic [ADDR_W-PAGE_W-1:0] base_o,
  output logic                     any_dirty_o,
  output logic                     rd_dirty_o,
  output logic [DATA_W-1:0]        rd_data_o
);
  localparam int SLOTS  = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] ptr_q;
  logic [BASE_W-1:0] base_q;
  logic [SLOTS-1:0]  dirty;
  logic [DATA_W-1:0] slot_data [SLOTS];

  // page base stays fixed, only the in-page pointer advances
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      base_q <= '0;
    end else if (load_i) begin
      base_q <= addr_i[ADDR_W-1:PAGE_W];
      ptr_q  <= addr_i[PAGE_W-1:0];
    end else if (wr_i) begin
      ptr_q  <= ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [DATA_W-1:0] d_q;
    logic              v_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= '0;
        v_q <= 1'b0;
      end else if (clear_i || load_i) begin
        v_q <= 1'b0;
      end else if (wr_i && ptr_q == PAGE_W'(g)) begin
        d_q <= data_i;
        v_q <= 1'b1;
      end
    end
    assign slot_data[g] = d_q;
    assign dirty[g]     = v_q;
  end

  assign base_o      = base_q;
  assign any_dirty_o = |dirty;
  assign rd_dirty_o  = dirty[rd_idx_i];
  assign rd_data_o   = slot_data[rd_idx_i];
endmodule

// File: rtl/pw_timer.sv
module pw_timer #(
  parameter int WC_CYCLES = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(WC_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (start_i)               cnt_q <= CNT_W'(WC_CYCLES - 1);
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/pw_seq.sv
module pw_seq #(
  parameter int PAGE_W    = 3,
  parameter int WC_CYCLES = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              supply_ok_i,
  input  logic              any_dirty_i,
  input  logic              rd_dirty_i,
  output logic [PAGE_W-1:0] idx_o,
  output logic              busy_o,
  output logic              fire_o,
  output logic              scan_done_o,
  output logic              drop_o
);
  import pw_pkg::*;

  localparam logic [PAGE_W-1:0] LAST = '1;

  pw_state_e         state_q, state_d;
  logic [PAGE_W-1:0] idx_q;
  logic              go, tmr_done;

  assign go          = (state_q == ST_IDLE) && stop_i && any_dirty_i && !wp_i && supply_ok_i;
  assign drop_o      = (state_q == ST_IDLE) && stop_i && !go;
  assign scan_done_o = (state_q == ST_SCAN) && (idx_q == LAST);
  assign fire_o      = (state_q == ST_SCAN) && rd_dirty_i && supply_ok_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go)          state_d = ST_SCAN;
      ST_SCAN: if (scan_done_o) state_d = ST_WAIT;
      ST_WAIT: if (tmr_done)    state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (go)                        idx_q <= '0;
      else if (state_q == ST_SCAN)   idx_q <= idx_q + 1'b1;
    end
  end

  pw_timer #(.WC_CYCLES(WC_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (scan_done_o),
    .run_i   (state_q == ST_WAIT),
    .done_o  (tmr_done)
  );

  assign idx_o  = idx_q;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/pw_page_commit.sv
module pw_page_commit #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 3,
  parameter int WC_CYCLES = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              supply_ok_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic              busy, accept;
  logic [BASE_W-1:0] base;
  logic [PAGE_W-1:0] idx;
  logic              any_dirty, rd_dirty, fire, scan_done, drop;
  logic [DATA_W-1:0] rd_data;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // front end refuses everything during the write cycle
  assign accept = !busy;

  pw_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (addr_load_i && accept),
    .addr_i      (addr_i),
    .wr_i        (byte_vld_i && accept),
    .data_i      (byte_i),
    .clear_i     ((start_i && accept) || drop || scan_done),
    .rd_idx_i    (idx),
    .base_o      (base),
    .any_dirty_o (any_dirty),
    .rd_dirty_o  (rd_dirty),
    .rd_data_o   (rd_data)
  );

  pw_seq #(.PAGE_W(PAGE_W), .WC_CYCLES(WC_CYCLES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stop_i      (stop_i),
    .wp_i        (wp_i),
    .supply_ok_i (supply_ok_i),
    .any_dirty_i (any_dirty),
    .rd_dirty_i  (rd_dirty),
    .idx_o       (idx),
    .busy_o      (busy),
    .fire_o      (fire),
    .scan_done_o (scan_done),
    .drop_o      (drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= fire;
      if (fire) begin
        addr_q <= {base, idx};
        data_q <= rd_data;
      end
    end
  end

  assign busy_o     = busy;
  assign mem_we_o   = we_q;
  assign mem_addr_o = addr_q;
  assign mem_data_o = data_q;
endmodule

// File: rtl/pw_page_commit_chk.sv
module pw_page_commit_chk #(
  parameter int PAGE_W    = 3,
  parameter int WC_CYCLES = 50
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic mem_we_o,
  input logic stop_i,
  input logic wp_i,
  input logic supply_ok_i
);
  localparam int TOTAL = (1 << PAGE_W) + WC_CYCLES;

  int busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= 0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  p_we_in_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  p_we_needs_supply_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> $past(supply_ok_i));

  p_busy_bounded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_cnt < TOTAL);

  p_busy_length_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_cnt == TOTAL);

  p_wp_no_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && wp_i && !busy_o) |=> !busy_o);

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !mem_we_o));
endmodule

bind pw_page_commit pw_page_commit_chk #(.PAGE_W(PAGE_W), .WC_CYCLES(WC_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .mem_we_o    (mem_we_o),
  .stop_i      (stop_i),
  .wp_i        (wp_i),
  .supply_ok_i (supply_ok_i)
);

// File: tb/sim_pw_page_commit.sv
module sim_pw_page_commit;
  localparam int WC    = 20;
  localparam int TOTAL = 8 + WC;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       addr_load_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       start_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       wp_i = 1'b0;
  logic       supply_ok_i = 1'b1;
  logic       busy_o, mem_we_o;
  logic [7:0] mem_addr_o, mem_data_o;

  always #10 clk_i = ~clk_i;

  pw_page_commit #(.WC_CYCLES(WC)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int         seen_cnt [256];
  logic [7:0] seen_dat [256];
  int         wr_total;
  logic [7:0] last_addr;
  bit         order_err;

  always @(negedge clk_i) begin
    if (rst_ni && mem_we_o) begin
      if (wr_total > 0 && mem_addr_o <= last_addr) order_err = 1;
      seen_cnt[mem_addr_o] = seen_cnt[mem_addr_o] + 1;
      seen_dat[mem_addr_o] = mem_data_o;
      last_addr = mem_addr_o;
      wr_total  = wr_total + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_seen();
    for (int i = 0; i < 256; i++) begin
      seen_cnt[i] = 0;
      seen_dat[i] = '0;
    end
    wr_total = 0;
    order_err = 0;
  endtask

  task automatic p_load(input logic [7:0] a);
    @(negedge clk_i); addr_load_i = 1; addr_i = a;
    @(negedge clk_i); addr_load_i = 0;
  endtask
  task automatic p_byte(input logic [7:0] d);
    @(negedge clk_i); byte_vld_i = 1; byte_i = d;
    @(negedge clk_i); byte_vld_i = 0;
  endtask
  task automatic p_start();
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
  endtask
  task automatic p_stop();
    @(negedge clk_i); stop_i = 1;
    @(negedge clk_i); stop_i = 0;
  endtask

  // at the negedge after the stop edge; counts busy cycles
  task automatic measure_busy(output int n);
    n = 0;
    while (busy_o) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic expect_idle(input string req);
    bit b = 0;
    for (int i = 0; i < 4; i++) begin
      if (busy_o) b = 1;
      @(negedge clk_i);
    end
    chk(!b, req, b, 0);
  endtask

  // {addr, nbytes, wp, seed}
  localparam logic [31:0] VECS [6] = '{
    {8'h10, 8'd1,  8'd0, 8'hA0},
    {8'h20, 8'd8,  8'd0, 8'h11},
    {8'h35, 8'd5,  8'd0, 8'h40},
    {8'h42, 8'd11, 8'd0, 8'h70},
    {8'h58, 8'd3,  8'd1, 8'h90},
    {8'hFE, 8'd4,  8'd0, 8'hC3}
  };

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    clear_seen();
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !mem_we_o, "R1 reset", {busy_o, mem_we_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o && !mem_we_o, "R1 after release", {busy_o, mem_we_o}, 0);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] a, seed;
      int nb;
      logic wp;
      logic [7:0] exp_d [8];
      bit exp_v [8];
      int exp_n, bad;
      a = VECS[v][31:24]; nb = int'(VECS[v][23:16]);
      wp = VECS[v][8]; seed = VECS[v][7:0];
      for (int o = 0; o < 8; o++) begin exp_v[o] = 0; exp_d[o] = '0; end
      for (int i = 0; i < nb; i++) begin
        exp_v[(int'(a[2:0]) + i) % 8] = 1;
        exp_d[(int'(a[2:0]) + i) % 8] = seed + 8'(i);
      end
      exp_n = 0;
      if (!wp) for (int o = 0; o < 8; o++) exp_n += exp_v[o];
      clear_seen();
      wp_i = wp;
      p_load(a);
      for (int i = 0; i < nb; i++) p_byte(seed + 8'(i));
      chk(wr_total == 0 && !busy_o, "R5 nothing before stop", wr_total, 0);
      p_stop();
      if (wp) begin
        expect_idle("R7 protected stop");
      end else begin
        measure_busy(n);
        chk(n == TOTAL, "R6 busy length", n, TOTAL);
        chk(!order_err, "R6 ascending order", order_err, 0);
      end
      wp_i = 0;
      chk(wr_total == exp_n, "R4 write count", wr_total, exp_n);
      bad = 0;
      for (int o = 0; o < 8; o++) begin
        int ad;
        ad = {a[7:3], 3'(o)};
        if (!wp && exp_v[o]) begin
          if (seen_cnt[ad] != 1 || seen_dat[ad] != exp_d[o]) bad++;
        end else if (seen_cnt[ad] != 0) bad++;
      end
      chk(bad == 0, "R2 R3 page contents", bad, 0);
    end

    // R9: repeated start discards buffered bytes
    clear_seen();
    p_load(8'h60); p_byte(8'h01); p_byte(8'h02);
    p_start(); p_stop();
    expect_idle("R9 start discards");
    chk(wr_total == 0, "R9 no writes", wr_total, 0);

    // R11: random-read setup then stop, and bare stop
    p_load(8'h61); p_start(); p_stop();
    expect_idle("R11 address only");
    p_stop();
    expect_idle("R11 bare stop");

    // R8: supply low at stop
    clear_seen();
    p_load(8'h80); p_byte(8'h55);
    supply_ok_i = 0;
    p_stop();
    expect_idle("R8 low supply at stop");
    supply_ok_i = 1;
    chk(wr_total == 0, "R8 no writes low supply", wr_total, 0);

    // R8: supply drops during walk
    clear_seen();
    p_load(8'h88); p_byte(8'h66); p_byte(8'h67);
    p_stop();
    supply_ok_i = 0;
    measure_busy(n);
    supply_ok_i = 1;
    chk(wr_total == 0, "R8 writes suppressed in walk", wr_total, 0);
    chk(n == TOTAL, "R8 cycle still timed", n, TOTAL);

    // R10: requests during busy are ignored
    clear_seen();
    p_load(8'h90); p_byte(8'h21);
    p_stop();
    repeat (10) @(negedge clk_i);
    chk(busy_o == 1, "R10 still busy", busy_o, 1);
    p_load(8'hA0); p_byte(8'h31); p_byte(8'h32); p_stop();
    while (busy_o) @(negedge clk_i);
    chk(wr_total == 1 && seen_dat[8'h90] == 8'h21, "R10 first commit only", wr_total, 1);
    p_stop();
    expect_idle("R10 busy-time bytes dropped");
    chk(seen_cnt[8'hA0] == 0, "R10 no write to ignored page", seen_cnt[8'hA0], 0);

    // R1: reset in the middle of a commit
    p_load(8'hB0); p_byte(8'h44); p_stop();
    @(negedge clk_i);
    rst_ni = 0;
    @(negedge clk_i);
    chk(!busy_o && !mem_we_o, "R1 mid-commit reset", busy_o, 0);
    rst_ni = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule